// File: doc/BRIEF.md
# Swap-Based Adaptive Sequential Address Codec

This block lowers switching on an address bus that mostly carries sequential addresses. Only the low `SYM_W` bits are encoded, with `SYM_W` between 1 and 4, because those bits toggle most often when addresses step by one. Each possible low-bit symbol owns a `SYM_W`-bit code held in a register. The encoder puts the code of the incoming symbol on the bus. It then exchanges that code with the code owned by the symbol's successor. When the next address is the successor, the bus therefore repeats the previous word and none of the encoded lines toggle. All upper address bits travel unchanged.

The receiving side holds a second copy of the same table. It finds the symbol whose code equals the received low bits, and it permutes its own table with the symbol it recovered. Encoder and decoder start from the same table at reset. They stay identical because both change only on valid transfers. The encoder output is registered. The decoder output is combinational from its code input. In a loopback connection the recovered address therefore appears in the cycle after the address is presented.

Top module: `swap_addr_codec`

## Requirements
- R1: After reset the table maps every symbol k to code k, `bus_out` is all zeros and `bus_valid` is 0.
- R2: An address presented with `in_valid` high appears on `bus_out` one clock later, with `bus_valid` high in that cycle. Its low `SYM_W` bits are the code the table held for the address's low `SYM_W` bits.
- R3: After a valid transfer of symbol A, the codes of A and (A+1) mod 2^SYM_W are exchanged. If the next valid symbol is A+1, the encoded low bits repeat the previous ones.
- R4: The successor of the all-ones symbol is symbol zero. With SYM_W=2, sending 3 and then 0 from reset gives code 3 both times.
- R5: With SYM_W=2, the symbol sequence 0,1,2,3,3,2,3,0,2,3,0 from reset produces the codes 0,0,0,0,1,3,3,3,0,0,0.
- R6: Bits `ADDR_W-1` down to `SYM_W` of `bus_out` equal the same bits of the registered address. The decoder copies those bits from `dec_code_in` unchanged.
- R7: A cycle with `in_valid` low leaves the table unchanged, holds `bus_out` and drives `bus_valid` low.
- R8: The decoder output's low bits are the unique symbol whose decoder-table code equals `dec_code_in[SYM_W-1:0]`. This output is combinational, with no register stage.
- R9: The decoder table permutes only on cycles where `dec_valid_in` is high, and it uses the decoded symbol to do so. With `bus_out` and `bus_valid` looped back, `dec_addr_out` equals the address that was sent.
- R10: Each table always holds a permutation of all 2^SYM_W codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for encoder and decoder |
| in_addr | input | ADDR_W | Address to encode |
| in_valid | input | 1 | Address is a transfer this cycle |
| bus_out | output | ADDR_W | Registered encoded bus word |
| bus_valid | output | 1 | `bus_out` carries a new transfer |
| dec_code_in | input | ADDR_W | Received encoded bus word |
| dec_valid_in | input | 1 | `dec_code_in` is a transfer this cycle |
| dec_addr_out | output | ADDR_W | Recovered address, combinational |

## Verification
The hardest state to reach from the ports is a scrambled table whose next output depends on a long history of swaps. The hardest check is that encoder and decoder still agree after idle gaps have interrupted that history. The stimulus builds such a table with a pseudo-random symbol stream that mixes sequential runs, wraps through the all-ones symbol, and idle cycles. The bench tracks the table in its own model and checks every bus word, and every recovered address, against that model.

// File: rtl/swap_codec_pkg.sv
package swap_codec_pkg;
  // Successor of a symbol, wrapping within 2^w values.
  function automatic int unsigned succ_sym(input int unsigned s, input int unsigned w);
    return (s + 1) % (1 << w);
  endfunction
endpackage

// File: rtl/swap_code_table.sv
module swap_code_table #(
  parameter int SYM_W = 2,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd,
  input  logic [SYM_W-1:0]               sym,
  output logic [NSYM-1:0][SYM_W-1:0]     codes
);
  import swap_codec_pkg::*;

  logic [SYM_W-1:0] nxt_sym;
  assign nxt_sym = SYM_W'(succ_sym(int'(sym), SYM_W));

  for (genvar k = 0; k < NSYM; k++) begin : g_entry
    logic is_cur, is_nbr;
    logic [SYM_W-1:0] nxt_code;
    assign is_cur = upd && (sym == SYM_W'(k));
    assign is_nbr = upd && (nxt_sym == SYM_W'(k));
    always_comb begin
      if (is_cur)      nxt_code = codes[nxt_sym];
      else if (is_nbr) nxt_code = codes[sym];
      else             nxt_code = codes[k];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) codes[k] <= SYM_W'(k);
      else        codes[k] <= nxt_code;
    end
  end

  // Coverage vector of codes present, built independently of the update logic.
  logic [NSYM-1:0] code_seen;
  always_comb begin
    code_seen = '0;
    for (int k = 0; k < NSYM; k++) code_seen[codes[k]] = 1'b1;
  end

  p_table_perm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(code_seen) == NSYM);
endmodule

// File: rtl/swap_sym_encoder.sv
module swap_sym_encoder #(
  parameter int ADDR_W = 32,
  parameter int SYM_W  = 2,
  localparam int NSYM  = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output logic [ADDR_W-1:0] bus,
  output logic              bus_valid
);
  logic [SYM_W-1:0]           sym;
  logic [NSYM-1:0][SYM_W-1:0] codes;
  logic [SYM_W-1:0]           sel_code;

  assign sym      = addr[SYM_W-1:0];
  assign sel_code = codes[sym];

  swap_code_table #(.SYM_W(SYM_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .upd(valid), .sym(sym), .codes(codes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus       <= '0;
      bus_valid <= 1'b0;
    end else begin
      bus_valid <= valid;
      if (valid) bus <= {addr[ADDR_W-1:SYM_W], sel_code};
    end
  end

  // Observation of the last valid symbol, used by the assertions only.
  logic [SYM_W-1:0] prev_sym;
  logic             prev_v;
  logic             seq_step;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sym <= '0;
      prev_v   <= 1'b0;
    end else if (valid) begin
      prev_sym <= sym;
      prev_v   <= 1'b1;
    end
  end
  assign seq_step = valid && prev_v && (sym == SYM_W'(prev_sym + 1'b1));

  p_seq_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step |=> (bus[SYM_W-1:0] == $past(bus[SYM_W-1:0])));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(bus) && !bus_valid));
  p_upper_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (bus[ADDR_W-1:SYM_W] == $past(addr[ADDR_W-1:SYM_W])));
endmodule

// File: rtl/swap_sym_decoder.sv
module swap_sym_decoder #(
  parameter int ADDR_W = 32,
  parameter int SYM_W  = 2,
  localparam int NSYM  = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] code_in,
  input  logic              valid_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [NSYM-1:0][SYM_W-1:0] codes;
  logic [NSYM-1:0]            hits;
  logic [SYM_W-1:0]           dec_sym;

  for (genvar k = 0; k < NSYM; k++) begin : g_cmp
    assign hits[k] = (codes[k] == code_in[SYM_W-1:0]);
  end

  always_comb begin
    dec_sym = '0;
    for (int k = 0; k < NSYM; k++)
      if (hits[k]) dec_sym = SYM_W'(k);
  end

  swap_code_table #(.SYM_W(SYM_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .upd(valid_in), .sym(dec_sym), .codes(codes)
  );

  assign addr_out = {code_in[ADDR_W-1:SYM_W], dec_sym};

  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> ($countones(hits) == 1));
endmodule

// File: rtl/swap_addr_codec.sv
module swap_addr_codec #(
  parameter int ADDR_W = 32,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_valid,
  output logic [ADDR_W-1:0] bus_out,
  output logic              bus_valid,
  input  logic [ADDR_W-1:0] dec_code_in,
  input  logic              dec_valid_in,
  output logic [ADDR_W-1:0] dec_addr_out
);
  initial begin
    p_width_ok: assert (SYM_W >= 1 && SYM_W <= 4 && ADDR_W > SYM_W);
  end

  swap_sym_encoder #(.ADDR_W(ADDR_W), .SYM_W(SYM_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .addr(in_addr), .valid(in_valid),
    .bus(bus_out), .bus_valid(bus_valid)
  );

  swap_sym_decoder #(.ADDR_W(ADDR_W), .SYM_W(SYM_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .code_in(dec_code_in), .valid_in(dec_valid_in),
    .addr_out(dec_addr_out)
  );
endmodule

// File: tb/swap_addr_codec_tb.sv
module swap_addr_codec_tb;
  localparam int AW = 32;
  localparam int SW = 2;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] bus_out, dec_addr_out;
  logic          bus_valid;

  int checks = 0;
  int errors = 0;
  int mtbl[NS];
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [AW-1:0] last_addr = '0;

  always #2 clk = ~clk;

  swap_addr_codec #(.ADDR_W(AW), .SYM_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .in_valid(in_valid),
    .bus_out(bus_out), .bus_valid(bus_valid),
    .dec_code_in(bus_out), .dec_valid_in(bus_valid), .dec_addr_out(dec_addr_out)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step_lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NS; k++) mtbl[k] = k;
    chk(bus_out == '0 && !bus_valid, "R1 reset outputs", bus_out, '0);
  endtask

  // Send one address; check the encoder word and the loopback recovery.
  task automatic send(input logic [AW-1:0] a, output int code);
    int s, n, t;
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    @(posedge clk); #1;
    s = int'(a[SW-1:0]);
    code = mtbl[s];
    chk(bus_valid, "R2 bus_valid", {31'b0, bus_valid}, 1);
    chk(bus_out[SW-1:0] == SW'(code), "R2 code", bus_out, AW'(code));
    chk(bus_out[AW-1:SW] == a[AW-1:SW], "R6 upper bits", bus_out, a);
    chk(dec_addr_out == a, "R8 R9 R10 recovery", dec_addr_out, a);
    n = (s + 1) % NS;
    t = mtbl[s]; mtbl[s] = mtbl[n]; mtbl[n] = t;
    last_addr = a;
  endtask

  task automatic t_identity();
    int c;
    do_reset();
    send(32'hA5A5_0002, c);
    chk(c == 2 && bus_out[SW-1:0] == 2'd2, "R1 identity code", bus_out, 2);
  endtask

  task automatic t_example();
    int seq[11] = '{0,1,2,3,3,2,3,0,2,3,0};
    int exp[11] = '{0,0,0,0,1,3,3,3,0,0,0};
    int c;
    do_reset();
    foreach (seq[i]) begin
      send(AW'(32'h0040_0000 + seq[i]), c);
      chk(bus_out[SW-1:0] == SW'(exp[i]), "R5 example code", bus_out, AW'(exp[i]));
    end
  endtask

  task automatic t_wrap();
    int c0, c1;
    do_reset();
    send(32'h0000_1003, c0);
    send(32'h0000_1004, c1);
    chk(bus_out[SW-1:0] == 2'd3, "R4 wrap to zero", bus_out, 3);
  endtask

  task automatic t_seq_run();
    logic [SW-1:0] first;
    int c;
    send(32'h0012_3451, c);
    first = bus_out[SW-1:0];
    for (int i = 1; i < 9; i++) begin
      send(32'h0012_3451 + AW'(i), c);
      chk(bus_out[SW-1:0] == first, "R3 sequential repeat", bus_out, AW'(first));
    end
  endtask

  task automatic t_idle();
    logic [AW-1:0] held;
    logic [SW-1:0] lastc;
    int c;
    held = bus_out;
    lastc = bus_out[SW-1:0];
    @(negedge clk);
    in_valid = 1'b0;
    in_addr = ~in_addr;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(bus_out == held && !bus_valid, "R7 idle hold", bus_out, held);
    end
    send(last_addr + 1, c);
    chk(bus_out[SW-1:0] == lastc, "R7 table unchanged by idle", bus_out, AW'(lastc));
  endtask

  task automatic t_random();
    int c;
    logic [AW-1:0] a;
    a = 32'h8000_0000;
    for (int i = 0; i < 300; i++) begin
      lfsr = step_lfsr(lfsr);
      if (lfsr[3:2] == 2'b00) a = {lfsr[31:8], 8'h00} | AW'(lfsr[1:0]);
      else a = a + 1;
      send(a, c);
      if (lfsr[7:4] == 4'hF) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk(!bus_valid, "R7 random idle", {31'b0, bus_valid}, 0);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_identity();
    t_example();
    t_wrap();
    t_seq_run();
    t_idle();
    do_reset();
    t_random();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule